// File: doc/BRIEF.md
# USB Full-Speed Receive Deserializer

This block turns the received full-speed USB line into bytes. It takes the differential receiver output and the two single-ended line levels, passes each through a synchronizer, and samples them with a clock running at four times the 12 Mbit/s bit rate. A phase tracker moves the sampling point back to the middle of the bit on every data transition. The receive sequencer then does the following:
- finds the SYNC pattern,
- decodes NRZI,
- discards stuffed zeros,
- packs the data bits into bytes, least significant bit first,
- detects the end-of-packet SE0.

Its output side follows UTMI receive conventions. `rx_active` frames a packet. `rx_valid` marks each byte on `rx_byte`. A single `rx_error` strobe covers three faults: a failed SYNC lock, a bad stuff bit, and an end of packet that arrives in the middle of a byte. The current line condition is always visible on `bus_state`. CRC checking and packet decoding belong to the link layer that sits above this block.

Top module: `usb_fs_rx_deser`

## Requirements
- R1: `bus_state` shows the synchronized single-ended levels as {positive, negative}: 2'b10 is J (idle), 2'b01 is K, and 2'b00 is SE0. A change on the pins reaches `bus_state` after two clock edges.
- R2: `rx_active` rises once the line has made at least SYNC_MIN_ZEROS (default 5) consecutive transitions starting from J, followed by one bit period with no transition. The receive line level is 1 for J and 0 for K. A line that stays idle at J never raises `rx_active`.
- R3: In NRZI decoding, a bit period with no level change is a 1 and a bit period with a level change is a 0. Bits are packed least significant bit first, so the first data bit received appears on `rx_byte[0]`. `rx_valid` is high for exactly one clock per completed byte, while `rx_active` is high, and `rx_byte` holds that byte during that clock.
- R4: A 0 that follows six consecutive 1s is a stuffed bit. It is dropped and never counted as data. The 1 that ends SYNC counts as the first 1 in the run.
- R5: If a 1 arrives where a stuffed 0 is required, `rx_error` pulses for one clock. No further `rx_valid` occurs until the end of that packet, and `rx_active` stays high until the end-of-packet sequence.
- R6: An SE0 sampled while a byte is only partly assembled pulses `rx_error` for one clock. Bytes that were already complete are still delivered.
- R7: A sync failure pulses `rx_error` for one clock and leaves `rx_active` low. A sync failure is at least one but fewer than SYNC_MIN_ZEROS transitions from idle, followed by a bit period with no transition.
- R8: `rx_active` stays high through the SE0 of the end of packet. It falls only after a J bit has been sampled following that SE0.
- R9: Data decode correctly when single bit periods are stretched to 5 clocks or shrunk to 3 clocks, provided each stretched or shrunk bit is followed by a transition. Sampling strobes are never on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, four times the bit rate (48 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_rcv | input | 1 | Differential receiver output, 1 = J level |
| line_pos | input | 1 | Single-ended level of the positive data line |
| line_neg | input | 1 | Single-ended level of the negative data line |
| rx_byte | output | 8 | Received data byte |
| rx_valid | output | 1 | One-clock strobe marking a new byte on rx_byte |
| rx_active | output | 1 | High from SYNC lock until after the end of packet |
| rx_error | output | 1 | One-clock strobe for a sync, stuff or partial-byte fault |
| bus_state | output | 2 | Synchronized line state: 10 J, 01 K, 00 SE0 |

## Verification
Several payloads are sent:
- Alternating bit patterns, where most bits are transitions.
- Bytes full of ones, which force stuffed zeros both inside a byte and across byte boundaries.
- A byte of all zeros with bit periods alternating between 5 and 3 clocks, which separates a phase tracker that follows edges from one that free-runs.

SYNC is sent with exactly the minimum number of transitions and with one fewer. This pins down the lock threshold. Packets are cut short in three places: by a seventh 1, by an SE0 three bits into a byte, and by an SE0 on a byte boundary. These show that each fault is reported only where it belongs and that earlier good bytes survive.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_ACTIVE = 2'd1,
    RX_ABORT  = 2'd2,
    RX_EOPW   = 2'd3
  } rx_state_e;

  localparam logic [1:0] BUS_J   = 2'b10;
  localparam logic [1:0] BUS_K   = 2'b01;
  localparam logic [1:0] BUS_SE0 = 2'b00;

endpackage

// File: rtl/usb_rx_line_sync.sv
module usb_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rcv_i,
  input  logic       pos_i,
  input  logic       neg_i,
  output logic       rcv_o,
  output logic       pos_o,
  output logic       neg_o,
  output logic       se0_o,
  output logic [1:0] bus_o
);

  logic [STAGES-1:0] rcv_q, pos_q, neg_q;
  logic [STAGES-1:0] rcv_n, pos_n, neg_n;

  // shift each pin into its own flop chain
  always_comb begin
    rcv_n = {rcv_q[STAGES-2:0], rcv_i};
    pos_n = {pos_q[STAGES-2:0], pos_i};
    neg_n = {neg_q[STAGES-2:0], neg_i};
  end

  // reset to the idle J condition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_q <= '1;
      pos_q <= '1;
      neg_q <= '0;
    end else begin
      rcv_q <= rcv_n;
      pos_q <= pos_n;
      neg_q <= neg_n;
    end
  end

  assign rcv_o = rcv_q[STAGES-1];
  assign pos_o = pos_q[STAGES-1];
  assign neg_o = neg_q[STAGES-1];
  assign se0_o = ~pos_o & ~neg_o;
  assign bus_o = {pos_o, neg_o};

endmodule

// File: rtl/usb_rx_phase_track.sv
module usb_rx_phase_track #(
  parameter int SAMPLES_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rcv_i,
  output logic strobe_o
);

  localparam int CW = (SAMPLES_PER_BIT > 2) ? $clog2(SAMPLES_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES_PER_BIT - 1);
  localparam logic [CW-1:0] MID  = CW'(SAMPLES_PER_BIT / 2 - 1);

  logic          rcv_prev_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          edge_seen;

  assign edge_seen = rcv_i ^ rcv_prev_q;

  // phase counter restarts on every data transition
  always_comb begin
    if (edge_seen)          cnt_n = '0;
    else if (cnt_q == LAST) cnt_n = '0;
    else                    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_prev_q <= 1'b1;
      cnt_q      <= '0;
    end else begin
      rcv_prev_q <= rcv_i;
      cnt_q      <= cnt_n;
    end
  end

  // sample near the middle of the bit, never on the edge cycle itself
  assign strobe_o = (cnt_q == MID) & ~edge_seen;

  // R9
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/usb_rx_sequencer.sv
module usb_rx_sequencer
  import usb_rx_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int SYNC_MIN_ZEROS  = 5,
  parameter int STUFF_LIMIT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              rcv_i,
  input  logic              se0_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              active_o,
  output logic              error_o
);

  localparam int ZW = $clog2(SYNC_MIN_ZEROS + 1);
  localparam int OW = $clog2(STUFF_LIMIT + 1);
  localparam int BW = $clog2(DATA_W);
  localparam logic [ZW-1:0] ZMAX  = ZW'(SYNC_MIN_ZEROS);
  localparam logic [OW-1:0] OMAX  = OW'(STUFF_LIMIT);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  rx_state_e         st_q, st_n;
  logic              prev_q, prev_n;
  logic [ZW-1:0]     zc_q, zc_n;
  logic [OW-1:0]     ones_q, ones_n;
  logic [BW-1:0]     bc_q, bc_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              valid_q, valid_n;
  logic              err_q, err_n;
  logic              dbit;
  logic [DATA_W-1:0] sh_shift;

  assign dbit     = (rcv_i == prev_q);
  assign sh_shift = {dbit, sh_q[DATA_W-1:1]};

  always_comb begin
    st_n    = st_q;
    prev_n  = prev_q;
    zc_n    = zc_q;
    ones_n  = ones_q;
    bc_n    = bc_q;
    sh_n    = sh_q;
    data_n  = data_q;
    valid_n = 1'b0;
    err_n   = 1'b0;
    if (strobe_i) begin
      if (se0_i) begin
        prev_n = 1'b1;
        case (st_q)
          RX_IDLE:   zc_n = '0;
          RX_ACTIVE: begin
            if (bc_q != '0) err_n = 1'b1;
            st_n = RX_EOPW;
          end
          RX_ABORT:  st_n = RX_EOPW;
          default:   ;
        endcase
      end else begin
        prev_n = rcv_i;
        case (st_q)
          RX_IDLE: begin
            if (!dbit) begin
              if (zc_q != ZMAX) zc_n = zc_q + 1'b1;
            end else if (zc_q == ZMAX) begin
              st_n   = RX_ACTIVE;
              ones_n = OW'(1);
              bc_n   = '0;
              zc_n   = '0;
            end else if (zc_q != '0) begin
              err_n = 1'b1;
              zc_n  = '0;
            end
          end
          RX_ACTIVE: begin
            if (ones_q == OMAX) begin
              if (dbit) begin
                err_n = 1'b1;
                st_n  = RX_ABORT;
              end else begin
                ones_n = '0;
              end
            end else begin
              sh_n   = sh_shift;
              ones_n = dbit ? ones_q + 1'b1 : '0;
              if (bc_q == BLAST) begin
                bc_n    = '0;
                data_n  = sh_shift;
                valid_n = 1'b1;
              end else begin
                bc_n = bc_q + 1'b1;
              end
            end
          end
          RX_EOPW: begin
            if (rcv_i) begin
              st_n = RX_IDLE;
              zc_n = '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      prev_q  <= 1'b1;
      zc_q    <= '0;
      ones_q  <= '0;
      bc_q    <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      prev_q  <= prev_n;
      zc_q    <= zc_n;
      ones_q  <= ones_n;
      bc_q    <= bc_n;
      sh_q    <= sh_n;
      data_q  <= data_n;
      valid_q <= valid_n;
      err_q   <= err_n;
    end
  end

  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign active_o = (st_q != RX_IDLE);
  assign error_o  = err_q;

  // R3
  valid_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> active_o);

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R5
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && error_o));

  // R2
  clean_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> !error_o);

  // R4
  ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OMAX);

endmodule

// File: rtl/usb_fs_rx_deser.sv
module usb_fs_rx_deser #(
  parameter int DATA_W          = 8,
  parameter int SAMPLES_PER_BIT = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int SYNC_MIN_ZEROS  = 5,
  parameter int STUFF_LIMIT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_rcv,
  input  logic              line_pos,
  input  logic              line_neg,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error,
  output logic [1:0]        bus_state
);

  logic rcv_s, pos_s, neg_s, se0_s, strobe;

  usb_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rcv_i (line_rcv),
    .pos_i (line_pos),
    .neg_i (line_neg),
    .rcv_o (rcv_s),
    .pos_o (pos_s),
    .neg_o (neg_s),
    .se0_o (se0_s),
    .bus_o (bus_state)
  );

  usb_rx_phase_track #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .rcv_i    (rcv_s),
    .strobe_o (strobe)
  );

  usb_rx_sequencer #(
    .DATA_W         (DATA_W),
    .SYNC_MIN_ZEROS (SYNC_MIN_ZEROS),
    .STUFF_LIMIT    (STUFF_LIMIT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe),
    .rcv_i    (rcv_s),
    .se0_i    (se0_s),
    .data_o   (rx_byte),
    .valid_o  (rx_valid),
    .active_o (rx_active),
    .error_o  (rx_error)
  );

  // R1
  bus_idle_no_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> (bus_state != 2'b00));

  // R8
  fall_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> (pos_s && !neg_s));

endmodule

// File: tb/sim_usb_fs_rx_deser.sv
module sim_usb_fs_rx_deser;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_rcv, line_pos, line_neg;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_active, rx_error;
  logic [1:0] bus_state;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  logic [7:0] got [0:15];
  int nv = 0, nerr = 0, nrise = 0, nfall = 0;
  logic act_prev = 1'b0;

  logic [7:0] tx_buf [0:15];
  bit cur = 1'b1;
  int ones = 0;
  bit stuff_en = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_fs_rx_deser u0 (
    .clk(clk), .rst_n(rst_n),
    .line_rcv(line_rcv), .line_pos(line_pos), .line_neg(line_neg),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_active(rx_active),
    .rx_error(rx_error), .bus_state(bus_state)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (nv < 16) got[nv] = rx_byte;
        nv = nv + 1;
      end
      if (rx_error) nerr = nerr + 1;
      if (rx_active && !act_prev) nrise = nrise + 1;
      if (!rx_active && act_prev) nfall = nfall + 1;
      act_prev = rx_active;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared = compared + 1;
    if (act != exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nv = 0; nerr = 0; nrise = 0; nfall = 0;
  endtask

  task automatic drive_lvl(input bit lv, input int n);
    line_rcv = lv; line_pos = lv; line_neg = ~lv;
    cur = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_se0(input int n);
    line_rcv = 1'b0; line_pos = 1'b0; line_neg = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int per);
    if (!b) cur = ~cur;
    drive_lvl(cur, per);
    if (b) ones = ones + 1; else ones = 0;
    if (stuff_en && ones == 6) begin
      drive_lvl(~cur, 4);
      ones = 0;
    end
  endtask

  task automatic send_sync(input int nz);
    for (int i = 0; i < nz; i++) send_bit(1'b0, 4);
    send_bit(1'b1, 4);
  endtask

  task automatic send_bytes(input int n);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) send_bit(tx_buf[k][i], 4);
  endtask

  task automatic send_eop();
    drive_se0(6);
    chk("R8 active during SE0", int'(rx_active), 1);
    drive_se0(2);
    drive_lvl(1'b1, 4);
    drive_lvl(1'b1, 8);
    chk("R8 active after EOP", int'(rx_active), 0);
    ones = 0;
  endtask

  task automatic idle(input int n);
    drive_lvl(1'b1, n);
  endtask

  task automatic t_reset();
    chk("R3 valid at reset", int'(rx_valid), 0);
    chk("R2 active at reset", int'(rx_active), 0);
    chk("R7 error at reset", int'(rx_error), 0);
    chk("R1 bus J at reset", int'(bus_state), 2);
    clear_mon();
    idle(64);
    chk("R2 idle no activity", nrise, 0);
    chk("R7 idle no error", nerr, 0);
  endtask

  task automatic t_line_state();
    clear_mon();
    drive_se0(3);
    chk("R1 bus SE0", int'(bus_state), 0);
    drive_se0(5);
    drive_lvl(1'b1, 3);
    chk("R1 bus J", int'(bus_state), 2);
    drive_lvl(1'b1, 5);
    drive_lvl(1'b0, 3);
    chk("R1 bus K", int'(bus_state), 1);
    drive_lvl(1'b0, 1);
    idle(24);
    chk("R7 two transitions then hold", nerr, 1);
    chk("R7 no lock", nrise, 0);
  endtask

  task automatic t_packet();
    clear_mon();
    tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C; tx_buf[2] = 8'h01; tx_buf[3] = 8'h80;
    send_sync(7);
    send_bytes(4);
    send_eop();
    idle(16);
    chk("R3 byte count", nv, 4);
    for (int i = 0; i < 4; i++) chk("R3 byte value", int'(got[i]), int'(tx_buf[i]));
    chk("R2 one lock", nrise, 1);
    chk("R8 one release", nfall, 1);
    chk("R6 no error on clean packet", nerr, 0);
  endtask

  task automatic t_stuff();
    clear_mon();
    tx_buf[0] = 8'hFF; tx_buf[1] = 8'h7E; tx_buf[2] = 8'hFF;
    send_sync(7);
    send_bytes(3);
    send_eop();
    idle(16);
    chk("R4 byte count", nv, 3);
    for (int i = 0; i < 3; i++) chk("R4 byte value", int'(got[i]), int'(tx_buf[i]));
    chk("R4 no error", nerr, 0);
  endtask

  task automatic t_stuff_err();
    clear_mon();
    stuff_en = 1'b0;
    tx_buf[0] = 8'hFF; tx_buf[1] = 8'h00;
    send_sync(7);
    send_bytes(2);
    stuff_en = 1'b1;
    send_eop();
    idle(16);
    chk("R5 one error", nerr, 1);
    chk("R5 no bytes", nv, 0);
    chk("R5 lock once", nrise, 1);
    chk("R5 release once", nfall, 1);
  endtask

  task automatic t_byte_err();
    clear_mon();
    tx_buf[0] = 8'hA5;
    send_sync(7);
    send_bytes(1);
    send_bit(1'b0, 4); send_bit(1'b1, 4); send_bit(1'b0, 4);
    send_eop();
    idle(16);
    chk("R6 one error", nerr, 1);
    chk("R6 good byte kept", nv, 1);
    chk("R6 byte value", int'(got[0]), 8'hA5);
  endtask

  task automatic t_sync_short();
    clear_mon();
    send_sync(4);
    idle(24);
    chk("R7 short sync error", nerr, 1);
    chk("R7 short sync no lock", nrise, 0);
    ones = 0;
  endtask

  task automatic t_sync_min();
    clear_mon();
    tx_buf[0] = 8'h5A;
    send_sync(5);
    send_bytes(1);
    send_eop();
    idle(16);
    chk("R2 minimum sync lock", nrise, 1);
    chk("R2 minimum sync byte", nv, 1);
    chk("R2 minimum sync value", int'(got[0]), 8'h5A);
    chk("R2 minimum sync no error", nerr, 0);
  endtask

  task automatic t_jitter();
    clear_mon();
    send_sync(7);
    for (int i = 0; i < 8; i++) send_bit(1'b0, (i % 2 == 0) ? 5 : 3);
    send_eop();
    idle(16);
    chk("R9 jitter byte count", nv, 1);
    chk("R9 jitter byte value", int'(got[0]), 0);
    chk("R9 jitter no error", nerr, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched = mismatched + 1;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    line_rcv = 1'b1; line_pos = 1'b1; line_neg = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_line_state();
    t_packet();
    t_stuff();
    t_stuff_err();
    t_byte_err();
    t_sync_short();
    t_sync_min();
    t_jitter();
    finish_run();
  end

endmodule